// File: doc/BRIEF.md
# GPIO Bank with Interrupt Summary

This block gives a processor register-level control over a parameterised set of general-purpose pins. Every pin owns a small group of memory-mapped registers. One holds the output-enable. One returns the synchronised pad input and holds the driven output value. One sets up interrupt detection. One holds the latched interrupt status. A separate register, in its own address window, selects where the pin's interrupt is routed. The block drives each pad's output and output-enable directly. It samples each pad input through a two-flop synchroniser.

Each pin detects a trigger on a level or on a single edge, with a programmable polarity. Two per-pin gates act independently. One decides whether a trigger updates the readable status bit. The other decides whether the trigger may raise an interrupt. Every pin whose interrupt is enabled, routed to the application processor and pending feeds one registered summary line. Software reacts to the summary by scanning the per-pin status registers, and it clears a pin by writing 1 to its status bit. Software emulates both-edge detection by flipping the polarity bit.

Top module: `gpiobank_top`

## Requirements
- R1: After reset, every output-enable, output value, interrupt configuration and status reads 0. Every routing register reads 7 (routed nowhere). `padOe`, `padOut` and `irqOut` are 0.
- R2: In the configuration register at 0x1000 + 0x10·pin, bit 9 drives `padOe[pin]`. In the data register at 0x1004 + 0x10·pin, bit 1 drives `padOut[pin]`. Both read back at the same positions.
- R3: Data register bit 0 returns the pad input after two clock edges of synchronisation. One edge after a pad change it still returns the old value.
- R4: In the interrupt configuration register at 0x1008 + 0x10·pin, bit 0 is the interrupt enable, bit 1 the polarity, bit 2 selects edge (1) or level (0), and bit 3 the status-update enable. In edge mode with polarity 1, a rising pad edge latches status bit 0 at 0x100C + 0x10·pin, and a falling edge does not.
- R5: In edge mode with polarity 0, a falling edge latches status and a rising edge does not.
- R6: In level mode the trigger follows the live pad level (high for polarity 1). A status clear while the level is still active leaves status set. A clear after the level has gone leaves it at 0.
- R7: With bit 3 at 0, a trigger leaves the status bit at 0. With bit 0 set, the trigger still raises `irqOut` when the pin is routed to the processor.
- R8: With bit 0 at 0, a trigger still sets status when bit 3 is 1, but `irqOut` stays low.
- R9: The routing register at 0x400 + 4·pin passes the pin's interrupt to `irqOut` only when it holds code 4. Code 7 blocks delivery. An edge caught while blocked is delivered once code 4 is written.
- R10: Writing 1 to status bit 0 clears the latched status and the edge pending state, and `irqOut` falls two edges later. Writing 0 has no effect.
- R11: Reads of unmapped, misaligned or out-of-range offsets, and reads with `busSel` low, return 0. Writes to such offsets change no pin state.
- R12: `irqOut` is the OR over all pins. It stays high while any delivering pin is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| padIn | input | NUM_PINS | Pad input levels (asynchronous) |
| padOut | output | NUM_PINS | Pad output values |
| padOe | output | NUM_PINS | Pad output enables |
| irqOut | output | 1 | Registered summary interrupt |

## Verification
The bench targets the independence of the two gates. A design that tied status capture to the interrupt enable would leave `irqOut` low when the status gate is off, or would show status when only the enable is off. It checks the edge polarity in both directions, because an inverted comparison would latch on the wrong transition. It checks that a level-mode clear is overridden while the level persists, because a design that latched level triggers like edges would lose that behaviour. It also checks that an edge caught while unrouted is still delivered after routing is turned on. Unmapped and misaligned addresses are probed to catch a decoder that aliases pins.

// File: rtl/gpiobank_pkg.sv
`timescale 1ns/1ps
package gpiobank_pkg;
  localparam int PIN_IDX_W = 8;

  // field positions that software relies on
  localparam int OE_BIT    = 9;
  localparam int IN_BIT    = 0;
  localparam int OUT_BIT   = 1;
  localparam int EN_BIT    = 0;
  localparam int POL_BIT   = 1;
  localparam int EDGE_BIT  = 2;
  localparam int RAW_BIT   = 3;
  localparam int STAT_BIT  = 0;
  localparam int ICFG_W    = 4;
  localparam int ROUTE_W   = 3;

  localparam logic [ROUTE_W-1:0] ROUTE_APP  = 3'd4;
  localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_CFG,
    KIND_DATA,
    KIND_ICFG,
    KIND_STAT,
    KIND_ROUTE
  } regKind_t;

  typedef struct packed {
    regKind_t               kind;
    logic [PIN_IDX_W-1:0]   pin;
    logic                   wrEn;
  } busStrobe_t;
endpackage

// File: rtl/gpiobank_ctrl.sv
`timescale 1ns/1ps
module gpiobank_ctrl
  import gpiobank_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 16
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] ROUTE_BASE = ADDR_W'('h400);
  localparam logic [ADDR_W-1:0] BANK_BASE  = ADDR_W'('h1000);
  localparam logic [ADDR_W-1:0] ROUTE_SPAN = ADDR_W'(4 * NUM_PINS);
  localparam logic [ADDR_W-1:0] BANK_SPAN  = ADDR_W'(16 * NUM_PINS);

  logic [ADDR_W-1:0] offRoute;
  logic [ADDR_W-1:0] offBank;

  assign offRoute = busAddr - ROUTE_BASE;
  assign offBank  = busAddr - BANK_BASE;

  always_comb begin
    strobe = '0;
    strobe.kind = KIND_NONE;
    if (busSel) begin
      if (busAddr >= ROUTE_BASE && offRoute < ROUTE_SPAN && offRoute[1:0] == 2'b00) begin
        strobe.kind = KIND_ROUTE;
        strobe.pin  = PIN_IDX_W'(offRoute >> 2);
      end else if (busAddr >= BANK_BASE && offBank < BANK_SPAN && offBank[1:0] == 2'b00) begin
        strobe.pin = PIN_IDX_W'(offBank >> 4);
        case (offBank[3:2])
          2'd0:    strobe.kind = KIND_CFG;
          2'd1:    strobe.kind = KIND_DATA;
          2'd2:    strobe.kind = KIND_ICFG;
          default: strobe.kind = KIND_STAT;
        endcase
      end
    end
    strobe.wrEn = busWr && (strobe.kind != KIND_NONE);
  end
endmodule

// File: rtl/gpiobank_datapath.sv
`timescale 1ns/1ps
module gpiobank_datapath
  import gpiobank_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strobe,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);
  logic [NUM_PINS-1:0]              oeVec, outVec, inVec, statVec, irqLine;
  logic [NUM_PINS-1:0][ICFG_W-1:0]  icfgVec;
  logic [NUM_PINS-1:0][ROUTE_W-1:0] routeVec;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic               hit, clr;
    logic               oeQ, outQ, statQ, pendQ;
    logic               syncA, syncB, prevQ;
    logic [ICFG_W-1:0]  icfgQ;
    logic [ROUTE_W-1:0] routeQ;
    logic               levelAct, edgeTrig, trig, pending;

    assign hit = strobe.wrEn && (strobe.pin == PIN_IDX_W'(p));
    assign clr = hit && strobe.kind == KIND_STAT && busWdata[STAT_BIT];

    assign levelAct = icfgQ[POL_BIT] ? syncB : ~syncB;
    assign edgeTrig = icfgQ[EDGE_BIT] &
                      (icfgQ[POL_BIT] ? (syncB & ~prevQ) : (~syncB & prevQ));
    assign trig     = icfgQ[EDGE_BIT] ? edgeTrig : levelAct;
    assign pending  = icfgQ[EDGE_BIT] ? pendQ : levelAct;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        oeQ    <= 1'b0;
        outQ   <= 1'b0;
        icfgQ  <= '0;
        routeQ <= ROUTE_NONE;
        statQ  <= 1'b0;
        pendQ  <= 1'b0;
        syncA  <= 1'b0;
        syncB  <= 1'b0;
        prevQ  <= 1'b0;
      end else begin
        if (hit && strobe.kind == KIND_CFG)   oeQ    <= busWdata[OE_BIT];
        if (hit && strobe.kind == KIND_DATA)  outQ   <= busWdata[OUT_BIT];
        if (hit && strobe.kind == KIND_ICFG)  icfgQ  <= busWdata[ICFG_W-1:0];
        if (hit && strobe.kind == KIND_ROUTE) routeQ <= busWdata[ROUTE_W-1:0];
        syncA <= padIn[p];
        syncB <= syncA;
        prevQ <= syncB;
        // a trigger in the same cycle as a clear wins, so nothing is lost
        statQ <= (statQ & ~clr) | (trig & icfgQ[RAW_BIT]);
        pendQ <= (pendQ & ~clr) | (edgeTrig & icfgQ[EN_BIT]);
      end
    end

    assign oeVec[p]    = oeQ;
    assign outVec[p]   = outQ;
    assign inVec[p]    = syncB;
    assign statVec[p]  = statQ;
    assign icfgVec[p]  = icfgQ;
    assign routeVec[p] = routeQ;
    assign irqLine[p]  = icfgQ[EN_BIT] & (routeQ == ROUTE_APP) & pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |irqLine;
  end

  always_comb begin
    busRdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (strobe.pin == PIN_IDX_W'(p)) begin
        case (strobe.kind)
          KIND_CFG:   busRdata[OE_BIT] = oeVec[p];
          KIND_DATA: begin
            busRdata[IN_BIT]  = inVec[p];
            busRdata[OUT_BIT] = outVec[p];
          end
          KIND_ICFG:  busRdata[ICFG_W-1:0]  = icfgVec[p];
          KIND_STAT:  busRdata[STAT_BIT]    = statVec[p];
          KIND_ROUTE: busRdata[ROUTE_W-1:0] = routeVec[p];
          default:    ;
        endcase
      end
    end
  end

  assign padOut = outVec;
  assign padOe  = oeVec;
endmodule

// File: rtl/gpiobank_top.sv
`timescale 1ns/1ps
module gpiobank_top
  import gpiobank_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);
  busStrobe_t strobe;

  gpiobank_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) ctrl_i (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gpiobank_datapath #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/gpiobank_chk.sv
`timescale 1ns/1ps
module gpiobank_chk #(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWr,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWdata,
  input logic [31:0]         busRdata,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe
);
  logic inRoute, inBank, mapped;
  assign inRoute = (busAddr >= ADDR_W'('h400)) && (busAddr < ADDR_W'('h400 + 4 * NUM_PINS));
  assign inBank  = (busAddr >= ADDR_W'('h1000)) && (busAddr < ADDR_W'('h1000 + 16 * NUM_PINS));
  assign mapped  = (inRoute || inBank) && (busAddr[1:0] == 2'b00);

  AST_PAD_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr) |=> ($stable(padOut) && $stable(padOe))); // R2

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !mapped) |-> (busRdata == 32'd0)); // R11

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (busRdata == 32'd0)); // R11

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pinchk
    AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr == ADDR_W'('h1000 + 16 * p))
      |=> (padOe[p] == $past(busWdata[9]))); // R2

    AST_OUT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr == ADDR_W'('h1004 + 16 * p))
      |=> (padOut[p] == $past(busWdata[1]))); // R2
  end
endmodule

bind gpiobank_top gpiobank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .padOut  (padOut),
  .padOe   (padOe)
);

// File: tb/gpiobank_tb_top.sv
`timescale 1ns/1ps
module gpiobank_tb_top;
  localparam int NP = 4;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe;
  logic          irqOut;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;

  gpiobank_top #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .irqOut(irqOut)
  );

  function automatic logic [AW-1:0] aCfg(int p);   return AW'('h1000 + 16 * p); endfunction
  function automatic logic [AW-1:0] aData(int p);  return AW'('h1004 + 16 * p); endfunction
  function automatic logic [AW-1:0] aIcfg(int p);  return AW'('h1008 + 16 * p); endfunction
  function automatic logic [AW-1:0] aStat(int p);  return AW'('h100C + 16 * p); endfunction
  function automatic logic [AW-1:0] aRoute(int p); return AW'('h400 + 4 * p);   endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic busWrite(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReg(string req, logic [AW-1:0] a, logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  task automatic setPad(int p, logic v);
    @(negedge clk);
    padIn[p] = v;
    waitCyc(5);
  endtask

  task automatic t_reset();
    for (int p = 0; p < NP; p++) begin
      expectReg("R1 cfg", aCfg(p), 0);
      expectReg("R1 icfg", aIcfg(p), 0);
      expectReg("R1 stat", aStat(p), 0);
      expectReg("R1 route", aRoute(p), 7);
    end
    check("R1 padOe", 32'(padOe), 0);
    check("R1 padOut", 32'(padOut), 0);
    check("R1 irq", 32'(irqOut), 0);
  endtask

  task automatic t_output();
    busWrite(aCfg(1), 32'h200);
    check("R2 padOe", 32'(padOe), 32'b0010);
    expectReg("R2 cfg readback", aCfg(1), 32'h200);
    busWrite(aData(1), 32'h2);
    check("R2 padOut", 32'(padOut), 32'b0010);
    expectReg("R2 data readback", aData(1), 32'h2);
    busWrite(aCfg(1), 32'h0);
    check("R2 padOe off", 32'(padOe), 0);
  endtask

  task automatic t_input_sync();
    logic [31:0] d;
    @(negedge clk);
    padIn[3] = 1'b1;
    busRead(aData(3), d);
    check("R3 after one edge", d & 1, 0);
    busRead(aData(3), d);
    check("R3 after two edges", d & 1, 1);
    setPad(3, 1'b0);
    expectReg("R3 low again", aData(3), 0);
  endtask

  task automatic t_rise_edge();
    busWrite(aRoute(0), 4);
    busWrite(aIcfg(0), 32'hF);
    setPad(0, 1'b1);
    expectReg("R4 rising latches", aStat(0), 1);
    check("R4 irq on rise", 32'(irqOut), 1);
    busWrite(aStat(0), 1);
    waitCyc(2);
    expectReg("R10 cleared", aStat(0), 0);
    check("R10 irq drops", 32'(irqOut), 0);
    setPad(0, 1'b0);
    expectReg("R4 falling ignored", aStat(0), 0);
    check("R4 no irq on fall", 32'(irqOut), 0);
  endtask

  task automatic t_fall_edge();
    busWrite(aRoute(1), 4);
    busWrite(aIcfg(1), 32'hD);
    setPad(1, 1'b1);
    expectReg("R5 rising ignored", aStat(1), 0);
    setPad(1, 1'b0);
    expectReg("R5 falling latches", aStat(1), 1);
    check("R5 irq on fall", 32'(irqOut), 1);
    busWrite(aStat(1), 1);
    waitCyc(2);
    check("R5 irq cleared", 32'(irqOut), 0);
  endtask

  task automatic t_level();
    busWrite(aRoute(2), 4);
    busWrite(aIcfg(2), 32'hB);
    setPad(2, 1'b1);
    expectReg("R6 level sets", aStat(2), 1);
    check("R6 level irq", 32'(irqOut), 1);
    busWrite(aStat(2), 1);
    waitCyc(1);
    expectReg("R6 re-set while active", aStat(2), 1);
    setPad(2, 1'b0);
    check("R6 irq follows level", 32'(irqOut), 0);
    busWrite(aStat(2), 1);
    waitCyc(1);
    expectReg("R6 clear sticks when inactive", aStat(2), 0);
    busWrite(aIcfg(2), 0);
  endtask

  task automatic t_gates();
    busWrite(aRoute(3), 4);
    busWrite(aIcfg(3), 32'h7);
    setPad(3, 1'b1);
    expectReg("R7 status not updated", aStat(3), 0);
    check("R7 irq still raised", 32'(irqOut), 1);
    busWrite(aStat(3), 1);
    waitCyc(2);
    check("R7 irq cleared", 32'(irqOut), 0);
    busWrite(aIcfg(3), 32'hE);
    setPad(3, 1'b0);
    setPad(3, 1'b1);
    expectReg("R8 status set with enable off", aStat(3), 1);
    check("R8 irq stays low", 32'(irqOut), 0);
    busWrite(aStat(3), 1);
    busWrite(aIcfg(3), 0);
  endtask

  task automatic t_route_w1c();
    busWrite(aRoute(0), 7);
    setPad(0, 1'b1);
    expectReg("R9 status when unrouted", aStat(0), 1);
    check("R9 code 7 blocks", 32'(irqOut), 0);
    busWrite(aStat(0), 0);
    expectReg("R10 write 0 no effect", aStat(0), 1);
    busWrite(aRoute(0), 4);
    waitCyc(2);
    check("R9 code 4 delivers", 32'(irqOut), 1);
    busWrite(aStat(0), 1);
    waitCyc(2);
    check("R10 irq after clear", 32'(irqOut), 0);
  endtask

  task automatic t_summary_or();
    setPad(0, 1'b0);
    setPad(0, 1'b1);
    setPad(1, 1'b1);
    setPad(1, 1'b0);
    check("R12 both pending", 32'(irqOut), 1);
    busWrite(aStat(0), 1);
    waitCyc(2);
    check("R12 one still pending", 32'(irqOut), 1);
    busWrite(aStat(1), 1);
    waitCyc(2);
    check("R12 none pending", 32'(irqOut), 0);
  endtask

  task automatic t_unmapped();
    expectReg("R11 offset 0", AW'('h0), 0);
    expectReg("R11 route past end", aRoute(NP), 0);
    expectReg("R11 bank past end", aCfg(NP), 0);
    expectReg("R11 misaligned", AW'('h1009), 0);
    busWrite(aCfg(NP), 32'hFFFF_FFFF);
    busWrite(AW'('h1001), 32'hFFFF_FFFF);
    check("R11 padOe untouched", 32'(padOe), 0);
    check("R11 padOut untouched", 32'(padOut), 32'b0010);
    expectReg("R11 pin0 cfg untouched", aCfg(0), 0);
  endtask

  initial begin
    #800000;
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_output();
    t_input_sync();
    t_rise_edge();
    t_fall_edge();
    t_level();
    t_gates();
    t_route_w1c();
    t_summary_or();
    busWrite(aData(1), 32'h2);
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule